// File: doc/BRIEF.md
# Micro-frame Index Counter with SOF Shadow

This block holds the running micro-frame index of a high-speed host controller and a slower 11-bit frame number that the bus side uses when it builds each start-of-frame token. The index advances on every micro-frame tick. The upper index bits also select the entry of the periodic frame list. Because one frame list entry covers eight micro-frames, each entry stays selected for eight ticks in a row.

The shadow frame number does not follow the index combinationally. It is a counter of its own. It steps once per millisecond, at the moment the three low index bits move from 000 to 001. Software can reload the index through a 32-bit register write port. It may do this only while the controller reports that it is halted, and only with a full-word write. An accepted write loads the index and copies its upper bits into the shadow in the same cycle, so the two counters stay in step. A one-cycle warning pulse flags any accepted value whose low three bits are 000 or 111. Software is expected to avoid these values.

Top module: `ufidx_sof_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the index, the shadow frame number and `wr_warn` all become zero.
- R2: When `uf_tick` is high and no write is accepted, the index increases by one at the clock edge. Without a tick or an accepted write, the index and the shadow hold their values.
- R3: `rd_data[13:0]` shows the index, and `rd_data[31:14]` always reads zero.
- R4: `fl_index` equals index bits [12:3], so each frame list entry is selected for eight consecutive ticks.
- R5: The shadow `sof_frame` increases by one only on a tick that moves the index low bits from 000 to 001.
- R6: The index wraps from 3FFFh to 0, and the shadow wraps from 7FFh to 0.
- R7: A write is accepted when `wr_en` and `halted` are high and `wr_be` is 1111b. On the next edge the index takes `wr_data[13:0]` and the shadow takes `wr_data[13:3]`.
- R8: A write while `halted` is low leaves the index and the shadow unchanged.
- R9: A write with any `wr_be` value other than 1111b leaves the index and the shadow unchanged.
- R10: When an accepted write and a tick fall in the same cycle, the written value is loaded and the tick is dropped.
- R11: `wr_warn` is high for exactly the cycle after an accepted write whose `wr_data[2:0]` is 000b or 111b. In every other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uf_tick | input | 1 | One-cycle pulse at the end of each micro-frame |
| halted | input | 1 | Controller halted status; gates writes |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Index register read value |
| fl_index | output | 10 | Frame list index |
| sof_frame | output | 11 | Shadow frame number for the SOF token |
| wr_warn | output | 1 | Pulse flagging an accepted write with low bits 000b or 111b |

## Verification
The hardest situation to reach is a shadow wrap: the shadow sits at 7FFh, the index crosses from 3FFFh to 0, and the next tick must then move the shadow to 0. Free counting would need about sixteen thousand ticks to get there. The stimulus instead performs a halted full-word write of 3FF9h and then ticks through the boundary. Coincident write-and-tick cycles and rejected writes with partial byte enables are produced both by directed steps and by the random mix.

// File: rtl/ufidx_pkg.sv
package ufidx_pkg;
  localparam int unsigned IDX_W_DEF  = 14;
  localparam int unsigned SUB_W_DEF  = 3;
  localparam int unsigned DATA_W_DEF = 32;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_TICK = 2'd1,
    UPD_LOAD = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/ufidx_wr_gate.sv
module ufidx_wr_gate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SUB_W  = 3,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              wr_en,
  input  logic              halted,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_acc,
  output logic              warn_nxt
);
  logic full_word;
  logic [SUB_W-1:0] low_bits;

  assign full_word = &wr_be;
  assign wr_acc    = wr_en & halted & full_word;
  assign low_bits  = wr_data[SUB_W-1:0];
  assign warn_nxt  = wr_acc & ((low_bits == '0) | (low_bits == '1));
endmodule

// File: rtl/ufidx_counter.sv
module ufidx_counter
  import ufidx_pkg::*;
#(
  parameter int unsigned IDX_W = 14,
  parameter int unsigned SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             uf_tick,
  input  logic             wr_acc,
  input  logic [IDX_W-1:0] wr_val,
  output logic [IDX_W-1:0] idx_q,
  output logic             sub_roll
);
  upd_kind_e kind;

  always_comb begin
    if (wr_acc)       kind = UPD_LOAD;
    else if (uf_tick) kind = UPD_TICK;
    else              kind = UPD_HOLD;
  end

  assign sub_roll = (kind == UPD_TICK) && (idx_q[SUB_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else begin
      unique case (kind)
        UPD_LOAD: idx_q <= wr_val;
        UPD_TICK: idx_q <= idx_q + 1'b1;
        default:  idx_q <= idx_q;
      endcase
    end
  end
endmodule

// File: rtl/sof_shadow.sv
module sof_shadow #(
  parameter int unsigned SHD_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SHD_W-1:0] load_val,
  input  logic             step,
  output logic [SHD_W-1:0] shd_q
);
  always_ff @(posedge clk) begin
    if (rst)       shd_q <= '0;
    else if (load) shd_q <= load_val;
    else if (step) shd_q <= shd_q + 1'b1;
  end
endmodule

// File: rtl/ufidx_sof_regs.sv
module ufidx_sof_regs
  import ufidx_pkg::*;
#(
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned SUB_W  = SUB_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned SHD_W = IDX_W - SUB_W,
  localparam int unsigned FL_W  = IDX_W - 1 - SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uf_tick,
  input  logic              halted,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [FL_W-1:0]   fl_index,
  output logic [SHD_W-1:0]  sof_frame,
  output logic              wr_warn
);
  logic             wr_acc;
  logic             warn_nxt;
  logic             sub_roll;
  logic [IDX_W-1:0] idx_q;

  ufidx_wr_gate #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_gate (
    .wr_en    (wr_en),
    .halted   (halted),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .wr_acc   (wr_acc),
    .warn_nxt (warn_nxt)
  );

  ufidx_counter #(.IDX_W(IDX_W), .SUB_W(SUB_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .uf_tick  (uf_tick),
    .wr_acc   (wr_acc),
    .wr_val   (wr_data[IDX_W-1:0]),
    .idx_q    (idx_q),
    .sub_roll (sub_roll)
  );

  sof_shadow #(.SHD_W(SHD_W)) u_shd (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_acc),
    .load_val (wr_data[IDX_W-1:SUB_W]),
    .step     (sub_roll),
    .shd_q    (sof_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_warn <= 1'b0;
    else     wr_warn <= warn_nxt;
  end

  assign rd_data  = {{(DATA_W-IDX_W){1'b0}}, idx_q};
  assign fl_index = idx_q[IDX_W-2:SUB_W];
endmodule

// File: rtl/ufidx_chk.sv
module ufidx_chk #(
  parameter int unsigned IDX_W  = 14,
  parameter int unsigned SUB_W  = 3,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned SHD_W = IDX_W - SUB_W,
  localparam int unsigned FL_W  = IDX_W - 1 - SUB_W
) (
  input logic              clk,
  input logic              rst,
  input logic              uf_tick,
  input logic              halted,
  input logic              wr_en,
  input logic [BE_W-1:0]   wr_be,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [FL_W-1:0]   fl_index,
  input logic [SHD_W-1:0]  sof_frame,
  input logic              wr_warn
);
  logic acc;
  assign acc = wr_en && halted && (wr_be == '1);

  AST_TICK_INC: assert property (@(posedge clk) disable iff (rst)
    (uf_tick && !acc) |=> rd_data[IDX_W-1:0] == IDX_W'($past(rd_data[IDX_W-1:0]) + 1'b1)); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!uf_tick && !acc) |=> ($stable(rd_data) && $stable(sof_frame))); // R8

  AST_SHADOW_STEP: assert property (@(posedge clk) disable iff (rst)
    (uf_tick && !acc && rd_data[SUB_W-1:0] == '0) |=> sof_frame == SHD_W'($past(sof_frame) + 1'b1)); // R5

  AST_SHADOW_STILL: assert property (@(posedge clk) disable iff (rst)
    (uf_tick && !acc && rd_data[SUB_W-1:0] != '0) |=> $stable(sof_frame)); // R5

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    acc |=> (rd_data[IDX_W-1:0] == $past(wr_data[IDX_W-1:0]) &&
             sof_frame == $past(wr_data[IDX_W-1:SUB_W]))); // R7

  AST_WARN_PULSE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !wr_warn); // R11

  AST_FL_MATCH: assert property (@(posedge clk) disable iff (rst)
    fl_index == rd_data[IDX_W-2:SUB_W]); // R4
endmodule

bind ufidx_sof_regs ufidx_chk #(.IDX_W(IDX_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .uf_tick(uf_tick), .halted(halted), .wr_en(wr_en),
  .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .fl_index(fl_index),
  .sof_frame(sof_frame), .wr_warn(wr_warn)
);

// File: tb/ufidx_sof_regs_tb.sv
module ufidx_sof_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        uf_tick = 1'b0;
  logic        halted = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [9:0]  fl_index;
  logic [10:0] sof_frame;
  logic        wr_warn;

  int n_chk = 0;
  int n_fail = 0;

  logic [13:0] m_idx = '0;
  logic [10:0] m_shd = '0;
  logic        m_warn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ufidx_sof_regs u_dut (
    .clk(clk), .rst(rst), .uf_tick(uf_tick), .halted(halted), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .fl_index(fl_index),
    .sof_frame(sof_frame), .wr_warn(wr_warn)
  );

  function automatic logic accepted(input logic we, input logic h, input logic [3:0] be);
    return we && h && (be == 4'hF);
  endfunction

  function automatic logic risky(input logic [31:0] d);
    return (d[2:0] == 3'b000) || (d[2:0] == 3'b111);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "index", {18'h0, rd_data[13:0]}, {18'h0, m_idx});
    check("R3", "reserved bits", {14'h0, rd_data[31:14]}, 32'h0);
    check("R4", "frame list index", {22'h0, fl_index}, {22'h0, m_idx[12:3]});
    check(req, "shadow", {21'h0, sof_frame}, {21'h0, m_shd});
    check("R11", "warn", {31'h0, wr_warn}, {31'h0, m_warn});
  endtask

  task automatic step(input string req, input logic tk, input logic h, input logic we,
                      input logic [3:0] be, input logic [31:0] d);
    uf_tick = tk; halted = h; wr_en = we; wr_be = be; wr_data = d;
    @(posedge clk);
    if (accepted(we, h, be)) begin
      m_warn = risky(d);
      m_idx  = d[13:0];
      m_shd  = d[13:3];
    end else begin
      m_warn = 1'b0;
      if (tk) begin
        if (m_idx[2:0] == 3'b000) m_shd = m_shd + 1'b1;
        m_idx = m_idx + 1'b1;
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // R2 / R5: count through the first frame boundaries
    for (int i = 0; i < 20; i++) step("R2", 1'b1, 1'b0, 1'b0, 4'h0, '0);
    step("R2", 1'b0, 1'b0, 1'b0, 4'h0, '0);
    step("R5", 1'b1, 1'b0, 1'b0, 4'h0, '0);

    // R7: accepted write, with and without warning
    step("R7", 1'b0, 1'b1, 1'b1, 4'hF, 32'hFFFF_1235);
    step("R7", 1'b0, 1'b1, 1'b1, 4'hF, 32'h0000_0A48);
    step("R7", 1'b0, 1'b0, 1'b0, 4'h0, '0);

    // R8: not halted
    step("R8", 1'b0, 1'b0, 1'b1, 4'hF, 32'h0000_2222);
    // R9: partial byte enables
    step("R9", 1'b0, 1'b1, 1'b1, 4'h3, 32'h0000_1111);
    step("R9", 1'b0, 1'b1, 1'b1, 4'h7, 32'h0000_3333);
    // R10: write and tick together
    step("R10", 1'b1, 1'b1, 1'b1, 4'hF, 32'h0000_0101);

    // R6: both wraps
    step("R6", 1'b0, 1'b1, 1'b1, 4'hF, 32'h0000_3FF9);
    for (int i = 0; i < 10; i++) step("R6", 1'b1, 1'b0, 1'b0, 4'h0, '0);

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    m_idx = '0; m_shd = '0; m_warn = 1'b0;
    @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // R2 R5 R7 R8 R9 R10 R11: random mix
    for (int i = 0; i < 4000; i++) begin
      logic tk, h, we;
      logic [3:0] be;
      tk = ($urandom % 3) == 0;
      h  = $urandom % 2;
      we = ($urandom % 10) < 3;
      be = (($urandom % 5) == 0) ? 4'($urandom) : 4'hF;
      step("R2/R7 random", tk, h, we, be, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule